// File: doc/BRIEF.md
# Trap Handler Privilege and Vector Generator

This block sits beside the trap logic of a processor core. When a trap is signalled it decides which privilege level will service it. It also builds the cause word that the handler will read and computes the address where the handler starts. Interrupts and exceptions are steered by separate delegation masks. Delegation runs in two stages: machine to supervisor, then supervisor to user.

A trap is presented for one cycle on `trapValid`, together with its kind, its 4-bit code and the privilege that was running. The handler privilege, cause word and target address are registered. They appear with a single-cycle `outValid` one clock later and hold their values until the next trap.

The block also owns the machine-level global interrupt enable. Reset clears it, and so does any trap serviced in machine mode. A simple write port sets or clears it at other times.

Top module: `trap_vector_gen`

## Requirements
- R1: While reset is asserted, and after its release until the first trap, `handlerPriv` is machine (3), `mIntEnable` is 0, `outValid` is 0, and `causeWord` and `targetPc` are zero.
- R2: When no delegation bit applies, the handler privilege is machine (3). Privilege encoding: user 0, supervisor 1, machine 3.
- R3: A trap raised from supervisor or user whose code bit is set in the machine delegation mask is handled in supervisor (1). A trap raised from machine is never delegated.
- R4: A trap raised from user is handled in user (0) only when its code bit is set in both the machine and the supervisor delegation masks. The supervisor bit alone leaves it in machine.
- R5: Interrupts consult only the two interrupt-delegation masks, and exceptions consult only the two exception-delegation masks. Bit n of a mask matches code n.
- R6: `causeWord` holds the code in bits [3:0] and zeros above it, except the most significant bit, which is 1 for an interrupt and 0 for an exception.
- R7: The trap-vector input used is the one of the chosen handler privilege: `mVec` for machine, `sVec` for supervisor, `uVec` for user.
- R8: The base address is the selected vector with bits [1:0] cleared. When bits [1:0] of the vector equal 01 and the trap is an interrupt, the target is base + 4*code. In every other case it is the base.
- R9: `outValid` pulses for exactly one cycle, on the clock edge after each `trapValid` cycle. Between traps, `handlerPriv`, `causeWord` and `targetPc` hold their values.
- R10: `mieWrEn` loads `mieWrData` into `mIntEnable` on the next edge. A trap handled in machine mode clears `mIntEnable`, and this wins over a write in the same cycle. A trap handled in a lower privilege leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | One-cycle trap strobe |
| isIrq | input | 1 | 1 = interrupt, 0 = exception |
| causeCode | input | 4 | Trap code |
| curPriv | input | 2 | Privilege at which the trap occurred |
| mExcDeleg | input | 16 | Machine exception-delegation mask |
| mIrqDeleg | input | 16 | Machine interrupt-delegation mask |
| sExcDeleg | input | 16 | Supervisor exception-delegation mask |
| sIrqDeleg | input | 16 | Supervisor interrupt-delegation mask |
| mVec | input | 32 | Machine trap vector (base plus mode bits [1:0]) |
| sVec | input | 32 | Supervisor trap vector |
| uVec | input | 32 | User trap vector |
| mieWrEn | input | 1 | Write strobe for the machine interrupt enable |
| mieWrData | input | 1 | Value to write to the machine interrupt enable |
| handlerPriv | output | 2 | Privilege chosen for the handler |
| causeWord | output | 32 | Cause word for the handler |
| targetPc | output | 32 | Handler start address |
| outValid | output | 1 | One-cycle result pulse |
| mIntEnable | output | 1 | Machine global interrupt enable |

## Verification
Every cycle, the assertions check these invariants:
- the pulse timing and the holding of results between traps;
- that a trap raised from machine never leaves machine;
- that a user handler only comes from user;
- that the cause MSB follows the trap kind;
- that machine-mode traps leave the interrupt enable cleared;
- that targets stay word aligned.

The exact delegation outcomes need the bench's directed scenarios. These cover the separation of interrupt and exception masks and the rule that both stages are needed for a user handler. The scenarios also check which vector is chosen and the arithmetic of the vectored offset. Each of these depends on specific mask and vector values.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } privLvl_e;

  localparam logic [1:0] VEC_MODE_VECTORED = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     isIrq;
    privLvl_e privSel;
    logic     clearMie;
    logic     writeMie;
    logic     mieVal;
  } trapStrobe_t;

endpackage

// File: rtl/trap_deleg_stage.sv
module trap_deleg_stage #(
  parameter int NUM_CAUSE = 16,
  localparam int CODE_W = $clog2(NUM_CAUSE)
) (
  input  logic [NUM_CAUSE-1:0] excMask,
  input  logic [NUM_CAUSE-1:0] irqMask,
  input  logic                 isIrq,
  input  logic [CODE_W-1:0]    code,
  input  logic                 eligible,
  output logic                 take
);

  logic [NUM_CAUSE-1:0] activeMask;

  always_comb begin
    activeMask = isIrq ? irqMask : excMask;
    take       = eligible && activeMask[code];
  end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int NUM_CAUSE = 16,
  localparam int CODE_W = $clog2(NUM_CAUSE),
  localparam int NUM_STAGE = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trapValid,
  input  logic                 isIrq,
  input  logic [CODE_W-1:0]    causeCode,
  input  logic [1:0]           curPriv,
  input  logic [NUM_CAUSE-1:0] mExcDeleg,
  input  logic [NUM_CAUSE-1:0] mIrqDeleg,
  input  logic [NUM_CAUSE-1:0] sExcDeleg,
  input  logic [NUM_CAUSE-1:0] sIrqDeleg,
  input  logic                 mieWrEn,
  input  logic                 mieWrData,
  output trapStrobe_t          strobe
);

  privLvl_e fromPriv;
  logic [NUM_CAUSE-1:0] stageExc [NUM_STAGE];
  logic [NUM_CAUSE-1:0] stageIrq [NUM_STAGE];
  logic [NUM_STAGE-1:0] stageElig;
  logic [NUM_STAGE-1:0] stageTake;
  privLvl_e chosenPriv;

  always_comb begin
    fromPriv     = privLvl_e'(curPriv);
    stageExc[0]  = mExcDeleg;
    stageIrq[0]  = mIrqDeleg;
    stageExc[1]  = sExcDeleg;
    stageIrq[1]  = sIrqDeleg;
    stageElig[0] = (fromPriv != PRIV_M);
    stageElig[1] = (fromPriv == PRIV_U);
  end

  // stage 0: machine -> supervisor, stage 1: supervisor -> user
  for (genvar g = 0; g < NUM_STAGE; g++) begin : gStage
    trap_deleg_stage #(.NUM_CAUSE(NUM_CAUSE)) u_stage (
      .excMask (stageExc[g]),
      .irqMask (stageIrq[g]),
      .isIrq   (isIrq),
      .code    (causeCode),
      .eligible(stageElig[g]),
      .take    (stageTake[g])
    );
  end

  always_comb begin
    chosenPriv = PRIV_M;
    if (stageTake[0]) begin
      chosenPriv = PRIV_S;
      if (stageTake[1]) chosenPriv = PRIV_U;
    end
  end

  always_comb begin
    strobe.capture  = trapValid;
    strobe.isIrq    = isIrq;
    strobe.privSel  = chosenPriv;
    strobe.clearMie = trapValid && (chosenPriv == PRIV_M);
    strobe.writeMie = mieWrEn;
    strobe.mieVal   = mieWrData;
  end

  AST_MACHINE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == 2'd3) |-> (strobe.privSel == PRIV_M)); // R3

  AST_USER_FROM_USER: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && strobe.privSel == PRIV_U) |-> (curPriv == 2'd0)); // R4

endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobe_t       strobe,
  input  logic [CODE_W-1:0] causeCode,
  input  logic [XLEN-1:0]   mVec,
  input  logic [XLEN-1:0]   sVec,
  input  logic [XLEN-1:0]   uVec,
  output logic [1:0]        handlerPriv,
  output logic [XLEN-1:0]   causeWord,
  output logic [XLEN-1:0]   targetPc,
  output logic              outValid,
  output logic              mIntEnable
);

  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [XLEN-1:0] selVec;
  logic [XLEN-1:0] vecBase;
  logic [XLEN-1:0] codeOffset;
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] causeNext;
  logic            useOffset;

  always_comb begin
    unique case (strobe.privSel)
      PRIV_S:  selVec = sVec;
      PRIV_U:  selVec = uVec;
      default: selVec = mVec;
    endcase
    vecBase    = {selVec[XLEN-1:2], 2'b00};
    codeOffset = XLEN'(causeCode) << 2;
    useOffset  = strobe.isIrq && (selVec[1:0] == VEC_MODE_VECTORED);
    pcNext     = useOffset ? (vecBase + codeOffset) : vecBase;
    causeNext  = {strobe.isIrq, {PAD_W{1'b0}}, causeCode};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      handlerPriv <= PRIV_M;
      causeWord   <= '0;
      targetPc    <= '0;
      outValid    <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        handlerPriv <= strobe.privSel;
        causeWord   <= causeNext;
        targetPc    <= pcNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                mIntEnable <= 1'b0;
    else if (strobe.clearMie) mIntEnable <= 1'b0;
    else if (strobe.writeMie) mIntEnable <= strobe.mieVal;
  end

  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> outValid); // R9

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.capture)); // R9

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(targetPc) && $stable(causeWord) && $stable(handlerPriv))); // R9

  AST_CAUSE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (causeWord[XLEN-1] == $past(strobe.isIrq))); // R6

  AST_MACHINE_TRAP_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && handlerPriv == 2'd3) |-> !mIntEnable); // R10

  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (targetPc[1:0] == 2'b00)); // R8

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_CAUSE = 16,
  localparam int CODE_W = $clog2(NUM_CAUSE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trapValid,
  input  logic                 isIrq,
  input  logic [CODE_W-1:0]    causeCode,
  input  logic [1:0]           curPriv,
  input  logic [NUM_CAUSE-1:0] mExcDeleg,
  input  logic [NUM_CAUSE-1:0] mIrqDeleg,
  input  logic [NUM_CAUSE-1:0] sExcDeleg,
  input  logic [NUM_CAUSE-1:0] sIrqDeleg,
  input  logic [XLEN-1:0]      mVec,
  input  logic [XLEN-1:0]      sVec,
  input  logic [XLEN-1:0]      uVec,
  input  logic                 mieWrEn,
  input  logic                 mieWrData,
  output logic [1:0]           handlerPriv,
  output logic [XLEN-1:0]      causeWord,
  output logic [XLEN-1:0]      targetPc,
  output logic                 outValid,
  output logic                 mIntEnable
);

  trapStrobe_t strobe;

  trap_ctrl #(.NUM_CAUSE(NUM_CAUSE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trapValid(trapValid),
    .isIrq    (isIrq),
    .causeCode(causeCode),
    .curPriv  (curPriv),
    .mExcDeleg(mExcDeleg),
    .mIrqDeleg(mIrqDeleg),
    .sExcDeleg(sExcDeleg),
    .sIrqDeleg(sIrqDeleg),
    .mieWrEn  (mieWrEn),
    .mieWrData(mieWrData),
    .strobe   (strobe)
  );

  trap_datapath #(.XLEN(XLEN), .CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .causeCode  (causeCode),
    .mVec       (mVec),
    .sVec       (sVec),
    .uVec       (uVec),
    .handlerPriv(handlerPriv),
    .causeWord  (causeWord),
    .targetPc   (targetPc),
    .outValid   (outValid),
    .mIntEnable (mIntEnable)
  );

endmodule

// File: tb/trap_vector_gen_tb.sv
module trap_vector_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        trapValid, isIrq;
  logic [3:0]  causeCode;
  logic [1:0]  curPriv;
  logic [15:0] mExcDeleg, mIrqDeleg, sExcDeleg, sIrqDeleg;
  logic [31:0] mVec, sVec, uVec;
  logic        mieWrEn, mieWrData;
  logic [1:0]  handlerPriv;
  logic [31:0] causeWord, targetPc;
  logic        outValid, mIntEnable;

  int vecCount  = 0;
  int missCount = 0;
  bit finished  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_vector_gen u_dut (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .isIrq(isIrq),
    .causeCode(causeCode), .curPriv(curPriv),
    .mExcDeleg(mExcDeleg), .mIrqDeleg(mIrqDeleg),
    .sExcDeleg(sExcDeleg), .sIrqDeleg(sIrqDeleg),
    .mVec(mVec), .sVec(sVec), .uVec(uVec),
    .mieWrEn(mieWrEn), .mieWrData(mieWrData),
    .handlerPriv(handlerPriv), .causeWord(causeWord), .targetPc(targetPc),
    .outValid(outValid), .mIntEnable(mIntEnable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearDeleg();
    mExcDeleg = '0; mIrqDeleg = '0; sExcDeleg = '0; sIrqDeleg = '0;
  endtask

  // strobe one trap; returns at the negedge after the capturing edge
  task automatic fire(input logic irq, input logic [3:0] code, input logic [1:0] cur);
    @(negedge clk);
    trapValid = 1'b1; isIrq = irq; causeCode = code; curPriv = cur;
    @(negedge clk);
    trapValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 priv", {30'd0, handlerPriv}, 32'd3);
    check("R1 mie", {31'd0, mIntEnable}, 32'd0);
    check("R1 valid", {31'd0, outValid}, 32'd0);
    check("R1 cause", causeWord, 32'd0);
    check("R1 pc", targetPc, 32'd0);
  endtask

  task automatic testDefaultMachine();
    clearDeleg();
    fire(1'b0, 4'd2, 2'd0);
    check("R2 priv", {30'd0, handlerPriv}, 32'd3);
    check("R9 valid", {31'd0, outValid}, 32'd1);
    check("R6 cause exc", causeWord, 32'h0000_0002);
    check("R8 exc no offset", targetPc, 32'h8000_0100);
    @(negedge clk);
    check("R9 valid drop", {31'd0, outValid}, 32'd0);
    check("R9 pc hold", targetPc, 32'h8000_0100);
    check("R9 cause hold", causeWord, 32'h0000_0002);
  endtask

  task automatic testIrqVectored();
    clearDeleg();
    fire(1'b1, 4'd7, 2'd3);
    check("R6 cause irq", causeWord, 32'h8000_0007);
    check("R8 vectored", targetPc, 32'h8000_011C);
    mVec = 32'h8000_0103;
    fire(1'b1, 4'd3, 2'd3);
    check("R8 mode3 base", targetPc, 32'h8000_0100);
    mVec = 32'h8000_0101;
  endtask

  task automatic testMachineNotDelegated();
    clearDeleg();
    mExcDeleg = 16'hFFFF; sExcDeleg = 16'hFFFF;
    fire(1'b0, 4'd5, 2'd3);
    check("R3 from M", {30'd0, handlerPriv}, 32'd3);
  endtask

  task automatic testSupervisor();
    clearDeleg();
    mExcDeleg = 16'h0020;
    fire(1'b0, 4'd5, 2'd1);
    check("R3 to S", {30'd0, handlerPriv}, 32'd1);
    check("R7 svec", targetPc, 32'h4000_0200);
    fire(1'b1, 4'd5, 2'd1);
    check("R5 irq ignores exc mask", {30'd0, handlerPriv}, 32'd3);
    mIrqDeleg = 16'h0020;
    fire(1'b1, 4'd5, 2'd1);
    check("R5 irq mask", {30'd0, handlerPriv}, 32'd1);
    check("R8 direct svec", targetPc, 32'h4000_0200);
  endtask

  task automatic testUser();
    clearDeleg();
    mIrqDeleg = 16'h0100; sIrqDeleg = 16'h0100;
    fire(1'b1, 4'd8, 2'd0);
    check("R4 to U", {30'd0, handlerPriv}, 32'd0);
    check("R7 uvec vectored", targetPc, 32'h2000_0320);
    fire(1'b1, 4'd8, 2'd1);
    check("R4 S stays S", {30'd0, handlerPriv}, 32'd1);
    fire(1'b0, 4'd8, 2'd0);
    check("R5 exc ignores irq mask", {30'd0, handlerPriv}, 32'd3);
    mIrqDeleg = '0;
    fire(1'b1, 4'd8, 2'd0);
    check("R4 s bit alone", {30'd0, handlerPriv}, 32'd3);
    clearDeleg();
    mExcDeleg = 16'h0100; sExcDeleg = 16'h0100;
    fire(1'b0, 4'd8, 2'd0);
    check("R4 exc to U", {30'd0, handlerPriv}, 32'd0);
    check("R8 exc uvec base", targetPc, 32'h2000_0300);
  endtask

  task automatic testMie();
    clearDeleg();
    @(negedge clk); mieWrEn = 1'b1; mieWrData = 1'b1;
    @(negedge clk); mieWrEn = 1'b0;
    check("R10 write", {31'd0, mIntEnable}, 32'd1);
    mExcDeleg = 16'h0004;
    fire(1'b0, 4'd2, 2'd1);
    check("R10 S trap keeps", {31'd0, mIntEnable}, 32'd1);
    fire(1'b0, 4'd3, 2'd1);
    check("R10 M trap clears", {31'd0, mIntEnable}, 32'd0);
    @(negedge clk);
    trapValid = 1'b1; isIrq = 1'b0; causeCode = 4'd3; curPriv = 2'd3;
    mieWrEn = 1'b1; mieWrData = 1'b1;
    @(negedge clk);
    trapValid = 1'b0; mieWrEn = 1'b0;
    check("R10 clear wins", {31'd0, mIntEnable}, 32'd0);
  endtask

  task automatic testMidReset();
    @(negedge clk); mieWrEn = 1'b1; mieWrData = 1'b1;
    @(negedge clk); mieWrEn = 1'b0;
    clearDeleg(); mExcDeleg = 16'h0002;
    fire(1'b0, 4'd1, 2'd1);
    check("R3 before reset", {30'd0, handlerPriv}, 32'd1);
    rstN = 1'b0;
    #1;
    check("R1 priv in reset", {30'd0, handlerPriv}, 32'd3);
    check("R1 mie in reset", {31'd0, mIntEnable}, 32'd0);
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; trapValid = 1'b0; isIrq = 1'b0; causeCode = '0; curPriv = '0;
    clearDeleg();
    mVec = 32'h8000_0101; sVec = 32'h4000_0200; uVec = 32'h2000_0301;
    mieWrEn = 1'b0; mieWrData = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDefaultMachine();
    testIrqVectored();
    testMachineNotDelegated();
    testSupervisor();
    testUser();
    testMie();
    testMidReset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule